// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block paces DRAM refresh and runs the refresh cycle itself. A free-running prescaler feeds an up-counter. When the counter equals a programmable interval value it wraps to zero and raises a refresh request. The request waits as a pending refresh until the bus grant input is high. The controller then runs a fixed three-state refresh cycle. A wait input can stretch that cycle, but only when the area is set for three-state access.

Software writes two registers through a small write port. One is a control word that holds the enable, the clock select and the access mode. The other is the interval compare value. After reset, and after each standby-exit strobe, the first request is only held. It does not take the bus. The request that follows it turns it into a live request. If a request arrives while a live one is still waiting, the two merge and a sticky overrun flag is set.

Top module: `refresh_ctrl`

## Requirements
- R1: The counter advances once per prescaler tick. Clock-select codes 1..7 give a tick every 2, 8, 32, 128, 512, 2048 and 4096 clocks. Code 0 stops the counter. Live cycle starts therefore repeat every (compare+1) × divide clocks.
- R2: A tick while the counter equals the compare value returns the counter to zero and raises one refresh request.
- R3: A write with `reg_sel`=1 loads the compare value and clears the counter in the same clock.
- R4: Control bit 0 is the enable. While it is 0, no request is kept, `bus_req` falls unless a cycle is running, and no cycle starts. The counter keeps running.
- R5: After reset or `standby_exit`, the first request is held without asserting `bus_req`. The next request makes it live.
- R6: `bus_req` is high while a live request waits or a refresh cycle runs. It is low from the clock after the cycle's last state, unless another live request exists. It is 0 after reset.
- R7: A cycle starts on the clock edge where `bus_gnt` is high and a live request exists. Without wait states, `rfsh_busy` is high for exactly 3 clocks and `rfsh_strobe` is high for the last 2 of them.
- R8: Control bit 4 selects three-state access. When it is 1, `wait_req` high holds the cycle in its second state. When it is 0, `wait_req` is ignored.
- R9: A request arriving while a live request is already pending merges with it and sets `overrun`. `overrun` stays set until reset.
- R10: A `standby_exit` pulse clears the counter and any pending request.

Control word layout: bit 0 enable, bits 3:1 clock select, bit 4 three-state access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the compare value |
| reg_wdata | input | 8 | Write data |
| standby_exit | input | 1 | One-clock pulse on leaving standby |
| bus_gnt | input | 1 | Bus grant |
| wait_req | input | 1 | Wait-state request |
| bus_req | output | 1 | Bus request |
| rfsh_busy | output | 1 | Refresh cycle in progress |
| rfsh_strobe | output | 1 | Refresh strobe, high in the second and third states |
| overrun | output | 1 | Sticky merged-request flag |

## Verification
A register write or a standby pulse takes effect at the next clock edge. A match turns a request live at the edge where the match happens, so `bus_req` is visible one clock later. A cycle starts at the first grant edge after that. A behavioural model in the bench advances at every rising edge. Outputs are compared only at falling edges, when every registered result of the previous edge has settled. The directed checks measure start-to-start periods, busy lengths and held-request windows as counts of rising edges, and use a bounded loop whenever the exact phase of the prescaler is not fixed.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam int PRE_W = 12;

    typedef struct packed {
        logic       area3;
        logic [2:0] cks;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_HELD = 2'd1,
        REQ_LIVE = 2'd2
    } req_e;

    typedef enum logic [1:0] {
        PH_T1 = 2'd0,
        PH_T2 = 2'd1,
        PH_T3 = 2'd2
    } phase_e;

    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] cks);
        int sh;
        case (cks)
            3'd1:    sh = 1;
            3'd2:    sh = 3;
            3'd3:    sh = 5;
            3'd4:    sh = 7;
            3'd5:    sh = 9;
            3'd6:    sh = 11;
            default: sh = 12;
        endcase
        div_mask = PRE_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/rfc_prescaler.sv
module rfc_prescaler
    import rfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cks,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        pre_d = pre_q + PRE_W'(1);
        mask  = div_mask(cks);
        tick  = (cks != 3'd0) && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/rfc_interval.sv
module rfc_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] cmp,
    output logic             match
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hit;

    always_comb begin
        hit   = (cnt_q == cmp);
        match = tick && hit && !clr;
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = hit ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfc_sequencer.sv
module rfc_sequencer
    import rfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic area3,
    input  logic standby,
    input  logic match,
    input  logic gnt,
    input  logic wait_req,
    output logic bus_req,
    output logic busy,
    output logic strobe,
    output logic ovr
);
    typedef struct packed {
        req_e   req;
        logic   first;
        logic   cyc;
        phase_e ph;
        logic   ovr;
    } seq_t;

    seq_t s_d, s_q;
    logic start;

    always_comb begin
        s_d   = s_q;
        start = !standby && en && (s_q.req == REQ_LIVE) && gnt && !s_q.cyc;

        if (start) begin
            s_d.cyc = 1'b1;
            s_d.ph  = PH_T1;
            s_d.req = REQ_NONE;
        end else if (s_q.cyc) begin
            case (s_q.ph)
                PH_T1:   s_d.ph = PH_T2;
                PH_T2:   if (!(area3 && wait_req)) s_d.ph = PH_T3;
                default: begin
                    s_d.cyc = 1'b0;
                    s_d.ph  = PH_T1;
                end
            endcase
        end

        if (standby) begin
            s_d.req   = REQ_NONE;
            s_d.first = 1'b1;
        end else if (!en) begin
            s_d.req = REQ_NONE;
        end else if (match) begin
            if (s_q.first) begin
                s_d.req   = REQ_HELD;
                s_d.first = 1'b0;
            end else if (s_d.req == REQ_LIVE) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.req = REQ_LIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.req   <= REQ_NONE;
            s_q.first <= 1'b1;
            s_q.cyc   <= 1'b0;
            s_q.ph    <= PH_T1;
            s_q.ovr   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req = (s_q.req == REQ_LIVE) || s_q.cyc;
    assign busy    = s_q.cyc;
    assign strobe  = s_q.cyc && (s_q.ph != PH_T1);
    assign ovr     = s_q.ovr;
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
    import rfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             standby_exit,
    input  logic             bus_gnt,
    input  logic             wait_req,
    output logic             bus_req,
    output logic             rfsh_busy,
    output logic             rfsh_strobe,
    output logic             overrun
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmp_wr, tick, match;
    logic  en_q, area_q;

    always_comb begin
        r_d    = r_q;
        cmp_wr = reg_we && reg_sel;
        if (reg_we && !reg_sel) r_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (cmp_wr)             r_d.cmp  = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.cmp  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_q   = r_q.ctrl.en;
    assign area_q = r_q.ctrl.area3;

    rfc_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .cks   (r_q.ctrl.cks),
        .tick  (tick)
    );

    rfc_interval #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (cmp_wr || standby_exit),
        .cmp   (r_q.cmp),
        .match (match)
    );

    rfc_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .area3    (area_q),
        .standby  (standby_exit),
        .match    (match),
        .gnt      (bus_gnt),
        .wait_req (wait_req),
        .bus_req  (bus_req),
        .busy     (rfsh_busy),
        .strobe   (rfsh_strobe),
        .ovr      (overrun)
    );
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_gnt,
    input logic standby_exit,
    input logic en_q,
    input logic area_q,
    input logic bus_req,
    input logic rfsh_busy,
    input logic rfsh_strobe,
    input logic overrun
);
    a_r6_busy_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_busy |-> bus_req);

    a_r7_busy_three: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_busy) |=> rfsh_busy ##1 rfsh_busy);

    a_r7_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_busy) |-> $past(bus_gnt));

    a_r8_two_state_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rfsh_strobe) && !area_q) |-> ##2 !rfsh_busy);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r10_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby_exit |=> (bus_req == rfsh_busy));

    a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (bus_req == rfsh_busy));
endmodule

bind refresh_ctrl refresh_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_gnt      (bus_gnt),
    .standby_exit (standby_exit),
    .en_q         (en_q),
    .area_q       (area_q),
    .bus_req      (bus_req),
    .rfsh_busy    (rfsh_busy),
    .rfsh_strobe  (rfsh_strobe),
    .overrun      (overrun)
);

// File: tb/refresh_ctrl_bench.sv
module refresh_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       standby_exit = 1'b0, bus_gnt = 1'b0, wait_req = 1'b0;
    logic       bus_req, rfsh_busy, rfsh_strobe, overrun;

    int n_chk = 0, n_err = 0, cyc_cnt = 0;
    string tag = "R6";

    always #4 clk = ~clk;

    refresh_ctrl u_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .standby_exit(standby_exit), .bus_gnt(bus_gnt),
        .wait_req(wait_req), .bus_req(bus_req), .rfsh_busy(rfsh_busy),
        .rfsh_strobe(rfsh_strobe), .overrun(overrun)
    );

    // behavioural reference: req 0 none, 1 held, 2 live; ph 0..2
    int m_pre, m_cnt, m_cmp, m_cks, m_ph, m_req;
    bit m_en, m_area, m_first, m_cyc, m_ovr;

    function automatic int div_of(int c);
        case (c)
            1: return 2;      2: return 8;      3: return 32;
            4: return 128;    5: return 512;    6: return 2048;
            default: return 4096;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_cmp = 255; m_cks = 0; m_en = 0; m_area = 0;
            m_first = 1; m_req = 0; m_cyc = 0; m_ph = 0; m_ovr = 0;
        end else begin
            bit tk, cw, mt, st;
            int nreq, ncyc, nph;
            cyc_cnt++;
            tk = (m_cks != 0) && ((m_pre % div_of(m_cks)) == div_of(m_cks) - 1);
            cw = reg_we && reg_sel;
            mt = tk && (m_cnt == m_cmp) && !standby_exit && !cw;
            st = !standby_exit && m_en && (m_req == 2) && bus_gnt && !m_cyc;
            nreq = m_req; ncyc = m_cyc; nph = m_ph;
            if (st) begin ncyc = 1; nph = 0; nreq = 0; end
            else if (m_cyc) begin
                if (m_ph == 0) nph = 1;
                else if (m_ph == 1) begin if (!(m_area && wait_req)) nph = 2; end
                else begin ncyc = 0; nph = 0; end
            end
            if (standby_exit) begin nreq = 0; m_first = 1; end
            else if (!m_en) nreq = 0;
            else if (mt) begin
                if (m_first) begin nreq = 1; m_first = 0; end
                else if (nreq == 2) m_ovr = 1;
                else nreq = 2;
            end
            if (standby_exit || cw) m_cnt = 0;
            else if (tk) m_cnt = (m_cnt == m_cmp) ? 0 : m_cnt + 1;
            m_req = nreq; m_cyc = ncyc; m_ph = nph;
            m_pre = (m_pre + 1) % 4096;
            if (cw) m_cmp = reg_wdata;
            if (reg_we && !reg_sel) begin
                m_en = reg_wdata[0]; m_cks = reg_wdata[3:1]; m_area = reg_wdata[4];
            end
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cyc_cnt);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        chk("R6", {tag, " bus_req"}, bus_req, int'((m_req == 2) || m_cyc));
        chk("R7", {tag, " busy"}, rfsh_busy, int'(m_cyc));
        chk("R7", {tag, " strobe"}, rfsh_strobe, int'(m_cyc && m_ph != 0));
        chk("R9", {tag, " overrun"}, overrun, int'(m_ovr));
    end

    always @(posedge clk) if (cyc_cnt > 150000) begin
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cyc_cnt);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    task automatic tick_n(input int n); repeat (n) @(negedge clk); endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_n(2); rst_n = 1'b1; tick_n(1);
    endtask

    task automatic wait_rise(output int t);
        logic was = rfsh_busy;
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rfsh_busy && !was) begin t = cyc_cnt; return; end
            was = rfsh_busy;
        end
    endtask

    task automatic busy_len(output int n);
        n = 1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rfsh_busy) n++; else return;
        end
    endtask

    initial begin
        int t0, t1, t2, n;
        do_reset();
        chk("R6", "reset bus_req", bus_req, 0);
        chk("R9", "reset overrun", overrun, 0);

        // R5 R7 R2: compare 3, divide 2 -> period 8
        tag = "R5"; bus_gnt = 1'b1;
        wr(1'b1, 8'd3); t0 = cyc_cnt; wr(1'b0, 8'h03);
        wait_rise(t1);
        chk("R5", "first request held (start delay >= 12)", int'(t1 - t0 >= 12), 1);
        busy_len(n);
        chk("R7", "busy length", n, 3);
        wait_rise(t2); wait_rise(t1);
        chk("R2", "start-to-start period", t1 - t2, 8);

        // R1: compare 1, divide 8 -> period 16
        tag = "R1";
        wr(1'b1, 8'd1); wr(1'b0, 8'h05);
        wait_rise(t0); wait_rise(t1); wait_rise(t2);
        chk("R1", "start-to-start period", t2 - t1, 16);

        // R8: wait ignored in two-state mode, honoured in three-state mode
        tag = "R8"; wait_req = 1'b1;
        wait_rise(t0); busy_len(n);
        chk("R8", "busy length with wait, two-state", n, 3);
        wr(1'b0, 8'h15);
        wait_rise(t0); tick_n(8);
        chk("R8", "busy held by wait, three-state", rfsh_busy, 1);
        wait_req = 1'b0;
        busy_len(n);
        chk("R8", "cycle ends after wait drops", int'(n < 5), 1);

        // R9: no grant, requests pile up
        tag = "R9"; bus_gnt = 1'b0;
        do_reset();
        chk("R9", "overrun cleared by reset", overrun, 0);
        wr(1'b1, 8'd1); wr(1'b0, 8'h03);
        tick_n(40);
        chk("R9", "overrun set", overrun, 1);
        chk("R9", "bus_req while pending", bus_req, 1);

        // R4: disable clears pending, re-enable resumes
        tag = "R4";
        wr(1'b0, 8'h02); tick_n(1);
        chk("R4", "bus_req after disable", bus_req, 0);
        tick_n(20);
        chk("R4", "no request while disabled", bus_req, 0);
        bus_gnt = 1'b1; t0 = cyc_cnt; wr(1'b0, 8'h03);
        wait_rise(t1);
        chk("R4", "cycle resumes after enable", int'(t1 > 0 && t1 - t0 <= 12), 1);

        // R10 R5: standby exit
        tag = "R10"; bus_gnt = 1'b0;
        tick_n(6);
        standby_exit = 1'b1; tick_n(1); standby_exit = 1'b0;
        tick_n(1);
        chk("R10", "pending cleared by standby exit", bus_req, 0);
        tick_n(5);
        chk("R5", "first request after standby held", bus_req, 0);
        tick_n(6);
        chk("R5", "second request live", bus_req, 1);

        // R3 and mixed traffic checked against the model each clock
        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            bus_gnt  = ($urandom % 4) != 0;
            wait_req = ($urandom % 3) == 0;
            standby_exit = ($urandom % 300) == 0;
            if (($urandom % 40) == 0) begin
                if ($urandom % 2) wr(1'b1, 8'($urandom % 6));
                else wr(1'b0, {3'b000, 1'($urandom), 2'd0, 1'b1 + 1'($urandom % 2), 1'(($urandom % 5) != 0)});
            end else tick_n(1);
        end
        standby_exit = 1'b0;
        tick_n(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule